// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises an interrupt request a programmed number of visible display lines after software arms it. Software writes an 8-bit reload value and an 8-bit live count through a simple write port. It also turns the interrupt on or off with address-selected writes. A per-line tick, qualified by a visible-line flag, moves the count toward zero while rendering is on. When an enabled count is found at zero on a visible tick, the request line goes high and stays high until software clears it.

The block also follows a personality selector. Writes to the counter and enable regions take effect only while the low two bits of the stored personality equal 1. Switching the personality to any other mode returns the counter to its reload value, turns the interrupt off and drops the request.

The write port is a valid/ready stream. The block never applies back-pressure: `wr_ready` is held high, so a write is taken on every cycle in which `wr_valid` is high. The other inputs are plain control pins sampled on every rising clock edge.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset, `irq_req` is 0 and the reload value, live count and enable flag are all 0.
- R2: `wr_ready` is always 1, and a write is accepted on every cycle with `wr_valid` high.
- R3: An accepted write with `wr_addr[15:12]` equal to 0xC or 0xD and `wr_addr[0]`=1 stores `wr_data` as the reload value.
- R4: An accepted write with `wr_addr[15:12]` equal to 0xC or 0xD and `wr_addr[0]`=0 loads `wr_data` straight into the live count.
- R5: An accepted write with `wr_addr[15:12]` equal to 0xE or 0xF and `wr_addr[0]`=1 sets the enable flag.
- R6: An accepted write with `wr_addr[15:12]` equal to 0xE or 0xF and `wr_addr[0]`=0 clears the enable flag, copies the reload value into the live count, and makes `irq_req` 0 on the next cycle.
- R7: A visible tick (`line_tick`=1 and `line_visible`=1) that finds the count at zero with the enable flag set drives `irq_req` to 1 on the next cycle and leaves the count at zero.
- R8: Any other visible tick decrements a nonzero count only when `render_on`=1; a count of zero never wraps.
- R9: A tick with `line_visible`=0 changes neither the count nor `irq_req`.
- R10: Once set, `irq_req` stays at 1 until a disable write (R6) or a personality exit (R11).
- R11: A `mode_wr` pulse whose `mode_val` differs from the stored personality and whose low two bits are not 1 copies the reload value into the count, clears the enable flag and makes `irq_req` 0. A pulse that repeats the stored value has no effect.
- R12: Writes to the 0xC–0xF regions are ignored while the stored personality's low two bits are not 1, and writes to any other region are always ignored. The personality is 0 after reset.
- R13: Within one cycle, a disable write or personality exit takes priority over a tick, and a count load (R4) takes priority over a tick decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accept, always 1 |
| wr_addr | input | 16 | Write address; bits 15:12 pick the region and bit 0 the function |
| wr_data | input | 8 | Write data |
| mode_wr | input | 1 | Personality change strobe |
| mode_val | input | 8 | New personality value |
| line_tick | input | 1 | One-cycle pulse per display line |
| line_visible | input | 1 | Current line is visible (lines 0 to 239) |
| render_on | input | 1 | Rendering is enabled |
| irq_req | output | 1 | Level interrupt request |

## Verification
The bound checker watches, on every cycle, the port-level rules: the ready line, that a request holds until a clearing event, that a disable write or personality exit always drops it, that it can only rise after a visible tick, and that an invisible tick or a zero count never moves the count. The exact cycle on which the request rises after a given count, the copying of the reload value on a disable, the aliasing of the 0xD and 0xF regions, and the cycle-level priority between writes and ticks are shown only by the bench. It runs directed scenarios and a long seeded random mix and compares `irq_req` on every cycle against a model built from the requirements.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

  // Region codes carried in the top nibble of the write address.
  localparam logic [3:0] RGN_CNT_A = 4'hC;
  localparam logic [3:0] RGN_CNT_B = 4'hD;
  localparam logic [3:0] RGN_EN_A  = 4'hE;
  localparam logic [3:0] RGN_EN_B  = 4'hF;

  // Personality low bits under which the counter registers are live.
  localparam logic [1:0] PERS_ACTIVE = 2'd1;

  // One-hot strobes decoded from an accepted write.
  typedef struct packed {
    logic reload_wr;  // store reload value
    logic count_wr;   // load live count
    logic arm;        // set enable
    logic disarm;     // clear enable, copy reload, drop request
  } irq_cmd_t;

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              pers_active,
  output irq_cmd_t          cmd
);

  localparam int RGN_LSB = ADDR_W - 4;

  logic [3:0] region;
  logic       sel_bit;
  logic       in_cnt_rgn;
  logic       in_en_rgn;
  logic       take;

  assign region     = wr_addr[ADDR_W-1:RGN_LSB];
  assign sel_bit    = wr_addr[0];
  assign in_cnt_rgn = (region == RGN_CNT_A) || (region == RGN_CNT_B);
  assign in_en_rgn  = (region == RGN_EN_A)  || (region == RGN_EN_B);
  assign take       = wr_fire && pers_active;

  always_comb begin
    cmd           = '0;
    cmd.reload_wr = take && in_cnt_rgn &&  sel_bit;
    cmd.count_wr  = take && in_cnt_rgn && !sel_bit;
    cmd.arm       = take && in_en_rgn  &&  sel_bit;
    cmd.disarm    = take && in_en_rgn  && !sel_bit;
  end

endmodule

// File: rtl/irq_mode_track.sv
module irq_mode_track
  import scanline_irq_pkg::*;
#(
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_val,
  output logic              pers_active,
  output logic              pers_exit
);

  logic [MODE_W-1:0] mode_q;
  logic              changed;

  assign changed     = mode_wr && (mode_val != mode_q);
  assign pers_exit   = changed && (mode_val[1:0] != PERS_ACTIVE);
  assign pers_active = (mode_q[1:0] == PERS_ACTIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (changed) begin
      mode_q <= mode_val;
    end
  end

endmodule

// File: rtl/irq_count_core.sv
module irq_count_core
  import scanline_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  irq_cmd_t         cmd,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             pers_exit,
  input  logic             tick_vis,
  input  logic             render_on,
  output logic             irq_req,
  output logic [CNT_W-1:0] count_q
);

  logic [CNT_W-1:0] reload_q;
  logic             armed_q;
  logic             req_q;
  logic             clear_all;
  logic             at_zero;
  logic             fire;

  assign clear_all = cmd.disarm || pers_exit;
  assign at_zero   = (count_q == '0);
  assign fire      = tick_vis && at_zero && armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (cmd.reload_wr) begin
      reload_q <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (clear_all) begin
      armed_q <= 1'b0;
    end else if (cmd.arm) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear_all) begin
      count_q <= reload_q;
    end else if (cmd.count_wr) begin
      count_q <= wr_val;
    end else if (tick_vis && !at_zero && render_on) begin
      count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (clear_all) begin
      req_q <= 1'b0;
    end else if (fire) begin
      req_q <= 1'b1;
    end
  end

  assign irq_req = req_q;

endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_val,
  input  logic              line_tick,
  input  logic              line_visible,
  input  logic              render_on,
  output logic              irq_req
);

  localparam int CNT_W = DATA_W;

  irq_cmd_t         cmd;
  logic             pers_active;
  logic             pers_exit;
  logic             tick_vis;
  logic [CNT_W-1:0] count_q;

  assign wr_ready = 1'b1;
  assign tick_vis = line_tick && line_visible;

  irq_mode_track #(.MODE_W(MODE_W)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wr     (mode_wr),
    .mode_val    (mode_val),
    .pers_active (pers_active),
    .pers_exit   (pers_exit)
  );

  irq_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_fire     (wr_valid && wr_ready),
    .wr_addr     (wr_addr),
    .pers_active (pers_active),
    .cmd         (cmd)
  );

  irq_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .wr_val    (wr_data),
    .pers_exit (pers_exit),
    .tick_vis  (tick_vis),
    .render_on (render_on),
    .irq_req   (irq_req),
    .count_q   (count_q)
  );

endmodule

// File: rtl/scanline_irq_checker.sv
module scanline_irq_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             line_tick,
  input logic             line_visible,
  input logic             mode_wr,
  input logic             irq_req,
  input logic             disarm,
  input logic             count_wr,
  input logic             pers_exit,
  input logic [CNT_W-1:0] count_q
);

  logic clear_evt;
  logic vis_tick;
  logic quiet;

  assign clear_evt = disarm || pers_exit;
  assign vis_tick  = line_tick && line_visible;
  assign quiet     = !(wr_valid && wr_ready) && !mode_wr;

  assert_ready_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready == 1'b1);

  assert_disarm_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> !irq_req);

  assert_rise_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !vis_tick) |=> !irq_req);

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !clear_evt && !count_wr) |=> (count_q == '0));

  assert_invisible_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!vis_tick && quiet) |=> ($stable(count_q) && $stable(irq_req)));

  assert_req_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !clear_evt) |=> irq_req);

  assert_exit_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pers_exit |=> !irq_req);

endmodule

bind scanline_irq_unit scanline_irq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .line_tick    (line_tick),
  .line_visible (line_visible),
  .mode_wr      (mode_wr),
  .irq_req      (irq_req),
  .disarm       (cmd.disarm),
  .count_wr     (cmd.count_wr),
  .pers_exit    (pers_exit),
  .count_q      (count_q)
);

// File: tb/tb_scanline_irq_unit.sv
`timescale 1ns/1ps
module tb_scanline_irq_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        mode_wr = 1'b0;
  logic [7:0]  mode_val = '0;
  logic        line_tick = 1'b0;
  logic        line_visible = 1'b0;
  logic        render_on = 1'b0;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model state built from the requirements.
  logic [7:0] m_reload, m_count, m_mode;
  logic       m_armed, m_req;

  always #10 clk = ~clk;

  scanline_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .mode_wr(mode_wr), .mode_val(mode_val),
    .line_tick(line_tick), .line_visible(line_visible), .render_on(render_on),
    .irq_req(irq_req)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit in_cnt(input logic [15:0] a);
    return a[15:12] == 4'hC || a[15:12] == 4'hD;
  endfunction

  function automatic bit in_en(input logic [15:0] a);
    return a[15:12] == 4'hE || a[15:12] == 4'hF;
  endfunction

  // Advance the model by one clock using the inputs now on the pins.
  task automatic model_step();
    bit active, take, clr, vtick;
    logic [7:0] n_reload, n_count;
    logic n_armed, n_req;
    active = (m_mode[1:0] == 2'd1);
    take   = wr_valid && active;
    clr    = (take && in_en(wr_addr) && !wr_addr[0]) ||
             (mode_wr && mode_val != m_mode && mode_val[1:0] != 2'd1);
    vtick  = line_tick && line_visible;
    n_reload = (take && in_cnt(wr_addr) && wr_addr[0]) ? wr_data : m_reload;
    n_armed  = clr ? 1'b0 : ((take && in_en(wr_addr) && wr_addr[0]) ? 1'b1 : m_armed);
    if (clr) n_count = m_reload;
    else if (take && in_cnt(wr_addr) && !wr_addr[0]) n_count = wr_data;
    else if (vtick && m_count != 0 && render_on) n_count = m_count - 8'd1;
    else n_count = m_count;
    n_req = clr ? 1'b0 : ((vtick && m_count == 0 && m_armed) ? 1'b1 : m_req);
    if (mode_wr && mode_val != m_mode) m_mode = mode_val;
    m_reload = n_reload; m_count = n_count; m_armed = n_armed; m_req = n_req;
  endtask

  task automatic drive(input bit wv, input logic [15:0] a, input logic [7:0] d,
                       input bit mw, input logic [7:0] mv,
                       input bit tk, input bit vis, input bit ren, input string tag);
    @(negedge clk);
    wr_valid = wv; wr_addr = a; wr_data = d;
    mode_wr = mw; mode_val = mv;
    line_tick = tk; line_visible = vis; render_on = ren;
    model_step();
    @(posedge clk);
    #2;
    check(tag, irq_req, m_req);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    drive(1'b1, a, d, 1'b0, 8'h0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic tick(input bit vis, input bit ren, input string tag);
    drive(1'b0, 16'h0, 8'h0, 1'b0, 8'h0, 1'b1, vis, ren, tag);
  endtask

  task automatic setmode(input logic [7:0] v, input string tag);
    drive(1'b0, 16'h0, 8'h0, 1'b1, v, 1'b0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_reload = 0; m_count = 0; m_mode = 0; m_armed = 0; m_req = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset irq_req", irq_req, 1'b0);
    check("R2 ready in reset", wr_ready, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // R12: personality 0 after reset, counter writes ignored.
    wr(16'hC000, 8'd0, "R12 ignored load");
    wr(16'hE001, 8'd0, "R12 ignored arm");
    tick(1, 1, "R12 no request while ignored");
    check("R12 arm ignored", irq_req, 1'b0);

    setmode(8'h01, "R11 enter active");
    wr(16'hC001, 8'd3, "R3 reload write");
    wr(16'hC000, 8'd2, "R4 count load");
    wr(16'hE001, 8'd0, "R5 arm");
    check("R2 ready", wr_ready, 1'b1);
    tick(1, 1, "R8 decrement 2->1");
    tick(1, 1, "R8 decrement 1->0");
    check("R7 not yet", irq_req, 1'b0);
    tick(1, 1, "R7 fire at zero");
    check("R7 request high", irq_req, 1'b1);
    tick(1, 1, "R10 sticky");
    tick(0, 1, "R9 invisible tick");
    check("R10 still high", irq_req, 1'b1);
    wr(16'hE000, 8'd0, "R6 disarm");
    check("R6 request dropped", irq_req, 1'b0);
    // count now holds reload 3: three decrements, then fire.
    wr(16'hF001, 8'd0, "R5 arm via alias");
    for (int i = 0; i < 3; i++) tick(1, 1, "R6 reload copied");
    check("R6 three ticks no fire", irq_req, 1'b0);
    tick(0, 1, "R9 invisible no fire");
    check("R9 invisible no fire", irq_req, 1'b0);
    tick(1, 1, "R6 fire after reload");
    check("R6 fire after reload", irq_req, 1'b1);

    // R11: repeat value has no effect; exit clears.
    setmode(8'h01, "R11 same value");
    check("R11 same value keeps request", irq_req, 1'b1);
    setmode(8'h02, "R11 exit");
    check("R11 exit clears", irq_req, 1'b0);
    wr(16'hD000, 8'd0, "R12 ignored in mode 2");
    setmode(8'h05, "R11 enter via 5");
    wr(16'hD001, 8'd1, "R3 alias reload");
    wr(16'hF000, 8'd0, "R6 alias disarm copies 1");
    wr(16'hE001, 8'd0, "R5 arm");
    tick(1, 0, "R8 render off holds");
    tick(1, 0, "R8 render off holds");
    check("R8 render off no fire", irq_req, 1'b0);
    tick(1, 1, "R8 decrement to 0");
    tick(1, 1, "R7 fire");
    check("R7 fire after render", irq_req, 1'b1);

    // R8 no wrap: disarmed at zero, ticks, then arm fires next tick.
    wr(16'hC001, 8'd0, "R3 reload zero");
    wr(16'hE000, 8'd0, "R6 disarm");
    for (int i = 0; i < 4; i++) tick(1, 1, "R8 zero holds");
    wr(16'hE001, 8'd0, "R5 arm");
    tick(1, 1, "R8 no wrap fire");
    check("R8 no wrap fire", irq_req, 1'b1);

    // R13 priorities.
    wr(16'hE000, 8'd0, "R6 disarm");
    wr(16'hE001, 8'd0, "R5 arm");
    drive(1'b1, 16'hE000, 8'd0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, "R13 disarm beats fire");
    check("R13 disarm beats fire", irq_req, 1'b0);
    wr(16'hC000, 8'd1, "R4 load 1");
    drive(1'b1, 16'hC000, 8'd1, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, "R13 load beats decrement");
    wr(16'hE001, 8'd0, "R5 arm");
    tick(1, 1, "R13 decrement 1->0");
    check("R13 no fire yet", irq_req, 1'b0);
    tick(1, 1, "R13 fire");
    check("R13 fire", irq_req, 1'b1);
    wr(16'h8000, 8'd0, "R12 other region");

    // Seeded random mix, compared against the model every cycle.
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0] mv;
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0: a = 16'hC000; 1: a = 16'hC001; 2: a = 16'hD000; 3: a = 16'hD001;
        4: a = 16'hE000; 5: a = 16'hE001; 6: a = 16'hF000; 7: a = 16'hF001;
        8: a = 16'h8000; default: a = 16'hA001;
      endcase
      r = $urandom_range(0, 4);
      mv = (r < 2) ? 8'h01 : (r == 2) ? 8'h05 : (r == 3) ? 8'h00 : 8'h02;
      drive($urandom_range(0, 3) == 0, a, 8'($urandom_range(0, 6)),
            $urandom_range(0, 30) == 0, mv,
            $urandom_range(0, 1) == 1, $urandom_range(0, 4) != 0,
            $urandom_range(0, 5) != 0, "R7/R8/R10/R13 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule